// File: doc/BRIEF.md
# Crypto DMA Channel with Descriptor Ring

This block is one DMA channel that serves a cipher engine. It walks a ring of two-word buffer descriptors held in memory. For each entry it first reads the buffer pointer and then the control word. If the full flag in the control word is set, the channel streams the buffer to the engine as 32-bit words. It then writes the control word back with the full flag cleared and moves on to the next entry. An entry whose full flag is clear stops the channel, and no transfer is made for that entry.

A stopped channel waits until software pulses the channel-enable write (`ce_wr`). The channel then fetches again from the same ring index. Each descriptor is marked as either a key buffer or a data buffer. Words from a key buffer reach the engine flagged as key material. A data buffer met before any key buffer has completed sets an error flag and stops the channel. A typical single-block run is a key descriptor followed by a data descriptor.

Top module: `crydma_top`

## Requirements
- R1: After reset the channel is stopped (`ch_active` low), `ch_err` is low, and `eng_valid`, `mem_re` and `mem_we` are all low.
- R2: A `ce_wr` pulse while stopped raises `ch_active` at the next edge. The first memory read then targets word 0 of the current descriptor, at address DESC_BASE + 2*index. Word 1, the control word, is at the following address.
- R3: When the fetched control word has bit 31 (full) clear, the channel sends no word to the engine and writes nothing back. It drops `ch_active` and keeps its ring index, so the next start fetches the same descriptor.
- R4: A `ce_wr` pulse while `ch_active` is high has no effect. This includes a pulse in the cycle where the channel stops.
- R5: When a descriptor with bit 16 clear (data) and bit 31 set is met before any descriptor with bit 16 set (key) has completed, `ch_err` is set, the channel stops, and no word is sent or written back. The next `ce_wr` clears `ch_err`.
- R6: A buffer of L bytes, where L is in bits 15:0 of the control word, is sent as ceil(L/4) words. The words are read from consecutive addresses starting at the pointer held in word 0. `eng_key` equals bit 16, and `eng_last` is high only on the final word.
- R7: While `eng_valid` is high and `eng_ready` is low, `eng_valid` stays high and `eng_data` stays unchanged.
- R8: After a buffer completes, the control word is written back with bit 31 cleared and every other bit unchanged.
- R9: After write-back, the index advances by one, or returns to 0 when bit 30 (wrap) of the control word is set.
- R10: A full descriptor with length 0 sends no words but is still written back and advanced past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_wr | input | 1 | Software write of 1 to the channel-enable bit |
| ch_active | output | 1 | Channel running (low when stopped) |
| ch_err | output | 1 | Data descriptor met before any key |
| mem_re | output | 1 | Memory read strobe, data returns one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| eng_valid | output | 1 | Word offered to the cipher engine |
| eng_ready | input | 1 | Engine accepts the word |
| eng_data | output | 32 | Word to the engine |
| eng_key | output | 1 | Word belongs to a key buffer |
| eng_last | output | 1 | Final word of the buffer |

## Verification
The stop and the restart can fall in the same cycle. The channel decodes a control word with the full flag clear in the same cycle that software writes channel-enable. The bench waits for the control-word read of the empty entry on the memory port and pulses `ce_wr` exactly one cycle later, when the decode happens. The bench judges that the stop wins: the channel must stay stopped and silent for many cycles. On a later pulse it must re-fetch the same index. Engine back-pressure is also applied during each transfer, pausing words on the engine handshake, and the bench checks that the offered word holds during every stall.

// File: rtl/crydma_pkg.sv
package crydma_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 16;
    localparam int FULL_BIT = 31;
    localparam int WRAP_BIT = 30;
    localparam int KEY_BIT  = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR,
        S_CTL,
        S_DEC,
        S_RD,
        S_CAP,
        S_SEND,
        S_WB
    } seq_state_e;

    typedef struct packed {
        logic             full;
        logic             wrap;
        logic             is_key;
        logic [LEN_W-1:0] len;
    } desc_ctl_t;

    function automatic desc_ctl_t unpack_ctl(input logic [WORD_W-1:0] w);
        desc_ctl_t d;
        d.full   = w[FULL_BIT];
        d.wrap   = w[WRAP_BIT];
        d.is_key = w[KEY_BIT];
        d.len    = w[LEN_W-1:0];
        return d;
    endfunction

    function automatic logic [LEN_W-1:0] words_of(input logic [LEN_W-1:0] len);
        logic [LEN_W+1:0] sum;
        sum = {2'b00, len} + (LEN_W+2)'(3);
        return sum[LEN_W+1:2];
    endfunction

    function automatic logic [WORD_W-1:0] drop_full(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[FULL_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/crydma_wake.sv
module crydma_wake (
    input  logic clk,
    input  logic rst,
    input  logic ce_wr,
    input  logic park_req,
    input  logic err_set,
    output logic active,
    output logic err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            err    <= 1'b0;
        end else if (active) begin
            if (park_req) active <= 1'b0;
            if (err_set)  err    <= 1'b1;
        end else if (ce_wr) begin
            active <= 1'b1;
            err    <= 1'b0;
        end
    end

    // R4
    ce_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        active && !park_req |=> active);

    // R3
    park_stops_chk: assert property (@(posedge clk) disable iff (rst)
        park_req |=> !active);

endmodule

// File: rtl/crydma_stream.sv
module crydma_stream #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_key,
    input  logic          ld_last,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          key,
    output logic          last,
    output logic          take
);

    assign take = valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
            key   <= 1'b0;
            last  <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= ld_data;
            key   <= ld_key;
            last  <= ld_last;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(data) && $stable(last));

endmodule

// File: rtl/crydma_seq.sv
module crydma_seq
    import crydma_pkg::*;
#(
    parameter int AW        = 8,
    parameter int IDXW      = 3,
    parameter int DESC_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    output logic              park_req,
    output logic              err_set,
    output logic              mem_re,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              st_load,
    output logic [WORD_W-1:0] st_data,
    output logic              st_key,
    output logic              st_last,
    input  logic              st_take
);

    localparam logic [AW-1:0] BASE = AW'(DESC_BASE);

    seq_state_e        state, state_n;
    logic [IDXW-1:0]   idx;
    logic [AW-1:0]     buf_ptr;
    logic [WORD_W-1:0] ctl_q;
    logic [LEN_W-1:0]  rem;
    logic              key_seen;
    logic [AW-1:0]     dbase;
    desc_ctl_t         dc;

    assign dbase = BASE + {{(AW-IDXW-1){1'b0}}, idx, 1'b0};
    assign dc    = unpack_ctl(mem_rdata);

    always_comb begin
        state_n   = state;
        park_req  = 1'b0;
        err_set   = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        st_load   = 1'b0;
        st_data   = mem_rdata;
        st_key    = ctl_q[KEY_BIT];
        st_last   = (rem == LEN_W'(1));
        case (state)
            S_IDLE: if (active) state_n = S_PTR;
            S_PTR: begin
                mem_re   = 1'b1;
                mem_addr = dbase;
                state_n  = S_CTL;
            end
            S_CTL: begin
                mem_re   = 1'b1;
                mem_addr = dbase + AW'(1);
                state_n  = S_DEC;
            end
            S_DEC: begin
                if (!dc.full) begin
                    park_req = 1'b1;
                    state_n  = S_IDLE;
                end else if (!dc.is_key && !key_seen) begin
                    park_req = 1'b1;
                    err_set  = 1'b1;
                    state_n  = S_IDLE;
                end else if (words_of(dc.len) == '0) begin
                    state_n = S_WB;
                end else begin
                    state_n = S_RD;
                end
            end
            S_RD: begin
                mem_re   = 1'b1;
                mem_addr = buf_ptr;
                state_n  = S_CAP;
            end
            S_CAP: begin
                st_load = 1'b1;
                state_n = S_SEND;
            end
            S_SEND: if (st_take) state_n = (rem == '0) ? S_WB : S_RD;
            S_WB: begin
                mem_we    = 1'b1;
                mem_addr  = dbase + AW'(1);
                mem_wdata = drop_full(ctl_q);
                state_n   = S_PTR;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            idx      <= '0;
            buf_ptr  <= '0;
            ctl_q    <= '0;
            rem      <= '0;
            key_seen <= 1'b0;
        end else begin
            state <= state_n;
            case (state)
                S_CTL: buf_ptr <= mem_rdata[AW-1:0];
                S_DEC: begin
                    ctl_q <= mem_rdata;
                    rem   <= words_of(dc.len);
                end
                S_CAP: begin
                    buf_ptr <= buf_ptr + AW'(1);
                    rem     <= rem - LEN_W'(1);
                end
                S_WB: begin
                    idx <= ctl_q[WRAP_BIT] ? '0 : idx + IDXW'(1);
                    if (ctl_q[KEY_BIT]) key_seen <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R5
    key_first_chk: assert property (@(posedge clk) disable iff (rst)
        st_load && !st_key |-> key_seen);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active && state == S_IDLE |-> !mem_re && !mem_we);

endmodule

// File: rtl/crydma_top.sv
module crydma_top
    import crydma_pkg::*;
#(
    parameter int AW        = 8,
    parameter int IDXW      = 3,
    parameter int DESC_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_wr,
    output logic              ch_active,
    output logic              ch_err,
    output logic              mem_re,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [WORD_W-1:0] eng_data,
    output logic              eng_key,
    output logic              eng_last
);

    logic              park_req, err_set;
    logic              st_load, st_key, st_last, st_take;
    logic [WORD_W-1:0] st_data;

    crydma_wake u_wake (
        .clk      (clk),
        .rst      (rst),
        .ce_wr    (ce_wr),
        .park_req (park_req),
        .err_set  (err_set),
        .active   (ch_active),
        .err      (ch_err)
    );

    crydma_seq #(
        .AW        (AW),
        .IDXW      (IDXW),
        .DESC_BASE (DESC_BASE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .active    (ch_active),
        .park_req  (park_req),
        .err_set   (err_set),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .st_load   (st_load),
        .st_data   (st_data),
        .st_key    (st_key),
        .st_last   (st_last),
        .st_take   (st_take)
    );

    crydma_stream #(.DW(WORD_W)) u_stream (
        .clk     (clk),
        .rst     (rst),
        .load    (st_load),
        .ld_data (st_data),
        .ld_key  (st_key),
        .ld_last (st_last),
        .ready   (eng_ready),
        .valid   (eng_valid),
        .data    (eng_data),
        .key     (eng_key),
        .last    (eng_last),
        .take    (st_take)
    );

    // R3
    send_while_active_chk: assert property (@(posedge clk) disable iff (rst)
        eng_valid |-> ch_active);

    // R8
    wb_only_active_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ch_active && !eng_valid);

endmodule

// File: tb/crydma_top_tb.sv
module crydma_top_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_wr = 1'b0;
    logic          ch_active, ch_err;
    logic          mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          eng_valid, eng_key, eng_last;
    logic          eng_ready = 1'b0;
    logic [31:0]   eng_data;

    logic [31:0] mem [0:255];
    logic [31:0] rx_data [0:63];
    logic        rx_key  [0:63];
    logic        rx_last [0:63];
    int          rx_n = 0;
    int          checks = 0, fails = 0, cyc = 0;
    int          stall_ev = 0, stall_bad = 0;
    logic        want_first = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic [7:0]  lfsr = 8'h5B;
    logic        pv = 1'b0, pr = 1'b0;
    logic [31:0] pd = '0;

    always #10 clk = ~clk;

    crydma_top #(.AW(AW), .IDXW(3), .DESC_BASE(0)) u_dut (
        .clk(clk), .rst(rst), .ce_wr(ce_wr),
        .ch_active(ch_active), .ch_err(ch_err),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_data(eng_data),
        .eng_key(eng_key), .eng_last(eng_last)
    );

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (rst) begin
            eng_ready = 1'b0;
            pv = 1'b0;
        end else begin
            if (pv && !pr) begin
                stall_ev++;
                if (!(eng_valid && eng_data == pd)) stall_bad++;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            eng_ready = lfsr[0] | lfsr[1];
            if (eng_valid && eng_ready && rx_n < 64) begin
                rx_data[rx_n] = eng_data;
                rx_key[rx_n]  = eng_key;
                rx_last[rx_n] = eng_last;
                rx_n++;
            end
            pv = eng_valid; pr = eng_ready; pd = eng_data;
            if (want_first && mem_re) begin
                first_addr = mem_addr;
                want_first = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input bit full, input bit wrap,
                                           input bit key, input int len);
        return {full, wrap, 13'd0, key, 16'(len)};
    endfunction

    task automatic put_desc(input int idx, input int ptr, input bit full,
                            input bit wrap, input bit key, input int len);
        mem[2*idx]   = 32'(ptr);
        mem[2*idx+1] = mk_ctl(full, wrap, key, len);
    endtask

    task automatic ce_pulse();
        @(negedge clk);
        want_first = 1'b1;
        ce_wr = 1'b1;
        @(negedge clk);
        ce_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (ch_active && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_buffer(input string req, input int ptr, input int len,
                                input bit key);
        int nw = (len + 3) / 4;
        check(rx_n == nw, req, rx_n, nw);
        for (int j = 0; j < nw && j < rx_n; j++) begin
            check(rx_data[j] == mem[ptr + j], req, rx_data[j], mem[ptr + j]);
            check(rx_key[j] == key, req, rx_key[j], key);
            check(rx_last[j] == (j == nw - 1), req, rx_last[j], j == nw - 1);
        end
    endtask

    initial begin
        int cur, nxt, quiet;
        bit wr;
        for (int a = 0; a < 256; a++) mem[a] = 32'hC0DE_0000 ^ (32'(a) * 32'h9E37);
        for (int i = 0; i < 8; i++) put_desc(i, 0, 1'b0, 1'b0, 1'b0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!ch_active, "R1", ch_active, 0);
        check(!ch_err, "R1", ch_err, 0);
        check(!eng_valid && !mem_re && !mem_we, "R1", {eng_valid, mem_re, mem_we}, 0);

        // R5 data before key
        put_desc(0, 100, 1'b1, 1'b0, 1'b0, 8);
        rx_n = 0;
        ce_pulse();
        check(ch_active, "R2", ch_active, 1);
        wait_idle();
        check(first_addr == 0, "R2", first_addr, 0);
        check(ch_err, "R5", ch_err, 1);
        check(rx_n == 0, "R5", rx_n, 0);
        check(mem[1] == mk_ctl(1, 0, 0, 8), "R5", mem[1], mk_ctl(1, 0, 0, 8));

        // key buffer, then stop on empty entry 1
        put_desc(0, 64, 1'b1, 1'b0, 1'b1, 16);
        rx_n = 0;
        ce_pulse();
        check(!ch_err, "R5", ch_err, 0);
        wait_idle();
        check(first_addr == 0, "R3", first_addr, 0);
        check_buffer("R6", 64, 16, 1'b1);
        check(mem[1] == mk_ctl(0, 0, 1, 16), "R8", mem[1], mk_ctl(0, 0, 1, 16));

        // sweep of data lengths, wrap at index 5
        cur = 1;
        for (int len = 0; len <= 12; len++) begin
            wr  = (cur == 5);
            nxt = wr ? 0 : (cur + 1) % 8;
            put_desc(cur, 128 + len * 8, 1'b1, wr, 1'b0, len);
            put_desc(nxt, 0, 1'b0, 1'b0, 1'b0, 0);
            rx_n = 0;
            ce_pulse();
            wait_idle();
            // R9 R3 fetch starts at the index left by the last stop
            check(first_addr == AW'(2 * cur), "R9", first_addr, 2 * cur);
            // R10 length zero gives no words
            check_buffer(len == 0 ? "R10" : "R6", 128 + len * 8, len, 1'b0);
            check(mem[2*cur+1] == mk_ctl(0, wr, 0, len), "R8",
                  mem[2*cur+1], mk_ctl(0, wr, 0, len));
            check(!ch_err, "R5", ch_err, 0);
            cur = nxt;
        end

        // R4 ce while transferring
        nxt = (cur + 1) % 8;
        put_desc(cur, 200, 1'b1, 1'b0, 1'b0, 20);
        put_desc(nxt, 0, 1'b0, 1'b0, 1'b0, 0);
        rx_n = 0;
        ce_pulse();
        while (rx_n < 1 && ch_active) @(negedge clk);
        ce_pulse();
        wait_idle();
        check_buffer("R4", 200, 20, 1'b0);
        quiet = 0;
        repeat (30) begin
            @(negedge clk);
            if (ch_active || mem_re) quiet++;
        end
        check(quiet == 0, "R4", quiet, 0);
        cur = nxt;

        // R4 ce in the very cycle of the stop decision
        nxt = (cur + 1) % 8;
        put_desc(cur, 220, 1'b1, 1'b0, 1'b0, 4);
        put_desc(nxt, 0, 1'b0, 1'b0, 1'b0, 0);
        rx_n = 0;
        ce_pulse();
        while (!(mem_re && mem_addr == AW'(2 * nxt + 1))) @(negedge clk);
        @(negedge clk);
        ce_wr = 1'b1;
        @(negedge clk);
        ce_wr = 1'b0;
        quiet = 0;
        repeat (30) begin
            @(negedge clk);
            if (ch_active || mem_re) quiet++;
        end
        check(quiet == 0, "R4", quiet, 0);
        check_buffer("R6", 220, 4, 1'b0);
        ce_pulse();
        wait_idle();
        check(first_addr == AW'(2 * nxt), "R3", first_addr, 2 * nxt);

        // R7 stall holds the offered word
        check(stall_ev > 0 && stall_bad == 0, "R7", stall_bad, 0);
        summary();
    end

endmodule